// File: doc/BRIEF.md
# Memory-Mapped Cyclic Keyboard Buffer

This block places a ring of sixteen 16-bit words in a CPU's word-addressed memory space, at word address 0x9000 through 0x900F. A keyboard front end offers key codes through a valid strobe and a 16-bit code. The block writes each accepted code into the ring slot that its internal write pointer selects, then moves the pointer on by one. After slot 0x900F the pointer wraps back to 0x9000. The CPU has no I/O instructions, so it reaches the ring only through ordinary loads and stores.

Software never sees head or tail registers. A word of zero means the slot is empty. Software polls a slot, takes a nonzero character from it, and stores zero to release the slot. The block never overwrites an unread character. A key aimed at an occupied slot is discarded, and a one-cycle drop pulse reports it. The bus passes any access outside the window to main memory unchanged.

Top module: `kbd_ring_mmio`

## Requirements
- R1: After synchronous reset, all sixteen slots read as zero and `key_drop` is low. The first accepted key lands at word address 0x9000.
- R2: An offered nonzero key whose target slot holds zero is stored in that slot at the clock edge. The write pointer then moves to the next slot in circular order, 0x9000 up to 0x900F and then back to 0x9000.
- R3: An offered nonzero key whose target slot is nonzero is discarded. The slot keeps its value, the pointer does not move, and `key_drop` is high in the following cycle.
- R4: An offered key code of zero is ignored. No slot changes, the pointer does not move, and `key_drop` stays low.
- R5: While `cpu_addr` lies in 0x9000 to 0x900F, `cpu_rdata` shows the addressed slot in the same cycle, and `mem_req` stays low.
- R6: A CPU write (`cpu_req` and `cpu_we` high) inside the window stores `cpu_wdata` in the addressed slot at the clock edge. Writing zero frees the slot for the producer.
- R7: When a CPU write and an offered nonzero key target the same slot in the same cycle, the CPU value is stored. The key is discarded with `key_drop` high the next cycle, and the pointer does not move.
- R8: Outside the window, `mem_req` equals `cpu_req`. `mem_addr`, `mem_wdata` and `mem_we` follow the CPU bus, `cpu_rdata` equals `mem_rdata`, and no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Producer offers a key code this cycle |
| key_code | input | 16 | Offered key code |
| cpu_req | input | 1 | CPU memory access strobe |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data to the CPU (ring slot or main memory) |
| mem_req | output | 1 | Access forwarded to main memory |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | 16 | Forwarded word address |
| mem_wdata | output | 16 | Forwarded write data |
| mem_rdata | input | 16 | Main memory read data, combinational |
| key_drop | output | 1 | Pulse: the key offered in the previous cycle was discarded |

## Verification
The assertions assume a clean synchronous reset at the start. They also assume that `mem_rdata` is a combinational response to the forwarded address. The pointer checks further assume that the producer offers at most one code per cycle and that no input is unknown once reset is released.

The bench drives every input on the falling edge and never leaves one undriven. It models main memory as a stateless function of the address, so the pass-through read check has a fixed expected value.

// File: rtl/kbr_pkg.sv
package kbr_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned RING_DEPTH = 16;
    localparam int unsigned IDX_W      = $clog2(RING_DEPTH);
    localparam logic [ADDR_W-1:0] RING_BASE = 16'h9000;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  slot_idx_t;

    typedef struct packed {
        logic      hit;
        logic      wr;
        slot_idx_t idx;
        word_t     wdata;
    } ring_access_t;

    typedef struct packed {
        logic  valid;
        word_t code;
    } key_offer_t;

    // Window test: upper address bits must equal those of the aligned base.
    function automatic logic in_window(addr_t a, addr_t base);
        return a[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W];
    endfunction

endpackage

// File: rtl/kbr_decode.sv
module kbr_decode
    import kbr_pkg::*;
#(
    parameter addr_t BASE = RING_BASE
) (
    input  logic         cpu_req,
    input  logic         cpu_we,
    input  addr_t        cpu_addr,
    input  word_t        cpu_wdata,
    output logic         sel_ring,
    output ring_access_t acc,
    output logic         mem_req,
    output logic         mem_we,
    output addr_t        mem_addr,
    output word_t        mem_wdata
);
    always_comb begin
        sel_ring  = in_window(cpu_addr, BASE);
        acc.hit   = cpu_req & sel_ring;
        acc.wr    = cpu_we;
        acc.idx   = cpu_addr[IDX_W-1:0];
        acc.wdata = cpu_wdata;
        mem_req   = cpu_req & ~sel_ring;
        mem_we    = cpu_we & mem_req;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
    end
endmodule

// File: rtl/kbr_ring.sv
module kbr_ring
    import kbr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  ring_access_t acc,
    input  key_offer_t   offer,
    output word_t        rd_data,
    output slot_idx_t    wr_ptr,
    output logic         drop
);
    word_t [RING_DEPTH-1:0] slot_all;
    slot_idx_t ptr_q;
    logic      drop_q;
    logic      want, tgt_full, collide, accept, cpu_wr;

    always_comb begin
        cpu_wr   = acc.hit & acc.wr;
        want     = offer.valid & (offer.code != '0);
        tgt_full = slot_all[ptr_q] != '0;
        collide  = cpu_wr & (acc.idx == ptr_q);
        accept   = want & ~tgt_full & ~collide;
    end

    for (genvar i = 0; i < RING_DEPTH; i++) begin : g_slot
        word_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (cpu_wr && acc.idx == slot_idx_t'(i))
                q <= acc.wdata;
            else if (accept && ptr_q == slot_idx_t'(i))
                q <= offer.code;
        end
        assign slot_all[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            drop_q <= 1'b0;
        end else begin
            if (accept)
                ptr_q <= ptr_q + 1'b1;
            drop_q <= want & ~accept;
        end
    end

    assign rd_data = slot_all[acc.idx];
    assign wr_ptr  = ptr_q;
    assign drop    = drop_q;
endmodule

// File: rtl/kbd_ring_mmio.sv
module kbd_ring_mmio
    import kbr_pkg::*;
#(
    parameter addr_t RING_BASE_ADDR = RING_BASE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_valid,
    input  logic [15:0] key_code,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        key_drop
);
    ring_access_t acc;
    key_offer_t   offer;
    logic         sel_ring;
    word_t        ring_rd;
    slot_idx_t    wr_ptr;

    assign offer.valid = key_valid;
    assign offer.code  = key_code;

    kbr_decode #(.BASE(RING_BASE_ADDR)) u_dec (
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .sel_ring (sel_ring),
        .acc      (acc),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    kbr_ring u_ring (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .offer  (offer),
        .rd_data(ring_rd),
        .wr_ptr (wr_ptr),
        .drop   (key_drop)
    );

    assign cpu_rdata = sel_ring ? ring_rd : mem_rdata;
endmodule

// File: rtl/kbr_checker.sv
module kbr_checker
    import kbr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        key_valid,
    input logic [15:0] key_code,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [15:0] mem_addr,
    input logic        mem_req,
    input logic        key_drop,
    input slot_idx_t   wr_ptr
);
    logic win;
    assign win = in_window(cpu_addr, RING_BASE);

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !win) |-> (mem_req && mem_addr == cpu_addr));

    // R5
    window_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && win) |-> !mem_req);

    // R4
    zero_key_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!(key_valid && key_code != '0)) |=> ($stable(wr_ptr) && !key_drop));

    // R3
    drop_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        key_drop |-> $stable(wr_ptr));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_ptr) |-> (wr_ptr == slot_idx_t'($past(wr_ptr) + 1'b1)));

    // R7
    collide_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (key_valid && key_code != '0 && cpu_req && cpu_we && win &&
         cpu_addr[IDX_W-1:0] == wr_ptr) |=> key_drop);
endmodule

bind kbd_ring_mmio kbr_checker u_chk (.*);

// File: tb/tb_kbd_ring_mmio.sv
module tb_kbd_ring_mmio;
    logic        clk = 1'b0;
    logic        rst;
    logic        key_valid, cpu_req, cpu_we;
    logic [15:0] key_code, cpu_addr, cpu_wdata;
    logic [15:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, key_drop;

    int n_cmp = 0, n_bad = 0;
    int mslot[16];
    int mptr;
    bit exp_drop;
    bit done = 0;

    always #4 clk = ~clk;

    // Stateless fake main memory
    assign mem_rdata = mem_addr ^ 16'hA5A5;

    kbd_ring_mmio dut (.*);

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One bus/producer cycle with reference model update and comparison.
    task automatic step(string tag, bit kv, int kc, bit rq, bit we, int addr, int wd);
        bit inwin, hit;
        int hidx;
        @(negedge clk);
        key_valid = kv; key_code = 16'(kc);
        cpu_req = rq; cpu_we = we; cpu_addr = 16'(addr); cpu_wdata = 16'(wd);
        #1;
        inwin = (addr >= 'h9000) && (addr <= 'h900F);
        hidx  = addr & 15;
        if (inwin) begin
            check(tag, cpu_rdata, mslot[hidx]);
            check(tag, mem_req, 0);
        end else begin
            check(tag, cpu_rdata, (addr ^ 'hA5A5) & 'hFFFF);
            check(tag, mem_req, rq);
            if (rq) begin
                check(tag, mem_addr, addr);
                check(tag, mem_wdata, wd);
                check(tag, mem_we, we);
            end
        end
        hit = rq && we && inwin;
        exp_drop = 0;
        if (kv && kc != 0) begin
            if (mslot[mptr] != 0 || (hit && hidx == mptr)) exp_drop = 1;
            else begin
                mslot[mptr] = kc;
                mptr = (mptr + 1) % 16;
            end
        end
        if (hit) mslot[hidx] = wd;
        @(posedge clk); #1;
        check(tag, key_drop, exp_drop);
    endtask

    task automatic rd(string tag, int addr);
        step(tag, 0, 0, 1, 0, addr, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        key_valid = 0; key_code = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        rst = 1;
        foreach (mslot[i]) mslot[i] = 0;
        mptr = 0;
        repeat (3) @(posedge clk);
        #1; check("R1", key_drop, 0);
        @(negedge clk); rst = 0;

        // R1: all slots empty after reset
        for (int i = 0; i < 16; i++) rd("R1", 'h9000 + i);

        // R2: three keys land in order
        step("R2", 1, 'h0041, 0, 0, 0, 0);
        step("R2", 1, 'h0042, 0, 0, 0, 0);
        step("R2", 1, 'h0043, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) rd("R2", 'h9000 + i);

        // R4: zero code ignored, next key goes to slot 3
        step("R4", 1, 0, 0, 0, 0, 0);
        step("R4", 1, 0, 1, 0, 'h9003, 0);
        step("R4", 1, 'h0044, 0, 0, 0, 0);
        rd("R4", 'h9003);

        // R2: fill to the end of the ring
        for (int i = 4; i < 16; i++) step("R2", 1, 'h0100 + i, 0, 0, 0, 0);
        rd("R2", 'h900F);

        // R3: ring full, key discarded
        step("R3", 1, 'h0BAD, 0, 0, 0, 0);
        rd("R3", 'h9000);

        // R6: free slot 0 by storing zero, wrap lands key there
        step("R6", 0, 0, 1, 1, 'h9000, 0);
        rd("R6", 'h9000);
        step("R2", 1, 'h0055, 0, 0, 0, 0);
        rd("R2", 'h9000);

        // R3: slot 1 still occupied
        step("R3", 1, 'h0066, 0, 0, 0, 0);
        rd("R3", 'h9001);

        // R6: nonzero CPU store into a slot
        step("R6", 0, 0, 1, 1, 'h9005, 'h7777);
        rd("R6", 'h9005);

        // R7: free slot 1, then collide producer and CPU on it
        step("R7", 0, 0, 1, 1, 'h9001, 0);
        step("R7", 1, 'h0088, 1, 1, 'h9001, 'h1234);
        rd("R7", 'h9001);
        step("R7", 0, 0, 1, 1, 'h9001, 0);
        step("R7", 1, 'h0099, 0, 0, 0, 0);
        rd("R7", 'h9001);

        // R8: pass-through just outside and far from the window
        step("R8", 0, 0, 1, 1, 'h8FFF, 'hCAFE);
        step("R8", 0, 0, 1, 1, 'h9010, 'hBEEF);
        rd("R8", 'h0000);
        rd("R8", 'hFFFF);
        step("R8", 0, 0, 0, 0, 'h1234, 0);
        rd("R8", 'h9000);
        rd("R8", 'h900F);

        finish_run();
    end
endmodule